// File: doc/BRIEF.md
# Boot Memory Chip-Select Controller

This block drives the chip select of the boot memory on a simple processor bus. From system reset it selects the boot device on every bus access, whatever the address. The processor can therefore fetch its initial stack pointer and program counter without any set-up. The device is treated as a 16-bit port with three wait states.

Software then loads a base address and a compare mask, and sets the valid bit in the control register. From then on the chip select answers only inside the programmed window. Once the block has left global decode it never returns to it unless a system reset occurs.

The block also times the data acknowledge from a programmable wait-state count, and reports the port width of the device it selects. The decision to select, the wait count and the port width are all captured when an access starts. A configuration write made during an access therefore changes only later accesses.

Top module: `boot_cs_ctrl`

## Requirements
- R1: After reset, and until a control write sets the valid bit, every access asserts `boot_cs` whatever `bus_addr` holds.
- R2: Reset leaves `boot_cs` and `boot_dack` low, `boot_port16` high, and the wait count at 3.
- R3: Straight after reset, four consecutive 16-bit accesses at byte addresses 0, 2, 4 and 6 are each selected with three wait states and a 16-bit width. These fetch the two halves of the stack pointer, then the two halves of the program counter.
- R4: With the valid bit set, an address hits when `(addr & ~mask) == (base & ~mask)` over all `ADDR_W` bits. A mask bit of 1 excludes that bit from the compare. The mask may contain holes.
- R5: Writing a control word with bit 0 set ends global decode permanently. After it, accesses outside the window get no `boot_cs` and no `boot_dack`.
- R6: A later control write with bit 0 clear does not restore global decode, and no access is selected after it. Only `rst` restores global decode.
- R7: The wait count is in control bits [5:2] and ranges from 0 to 15. `boot_cs` rises on the first clock edge that samples `bus_as` high with a hit. `boot_dack` rises exactly wait-count + 1 edges later and is never high without `boot_cs`.
- R8: Control bit 1 selects the port width: 0 means 8-bit and 1 means 16-bit. `boot_port16` takes this value when a selected access starts.
- R9: `boot_cs` and `boot_dack` fall on the first clock edge that samples `bus_as` low.
- R10: A configuration write made during an access leaves the current access's select, wait count and port width unchanged. It applies from the next access onward.
- R11: `cfg_sel` picks the register written when `cfg_we` is high: 0 writes the base, 1 writes the mask, 2 writes the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| bus_addr | input | ADDR_W | Bus byte address, stable while `bus_as` is high |
| bus_as | input | 1 | Address strobe, high for the whole access |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 base, 1 mask, 2 control |
| cfg_wdata | input | ADDR_W | Configuration write data |
| boot_cs | output | 1 | Registered boot-memory chip select |
| boot_dack | output | 1 | Registered data acknowledge |
| boot_port16 | output | 1 | Port width of the selected device, 1 = 16-bit |

## Verification
A stuck or wrongly cleared global flag shows at the ports on the very next access. The boot memory is then selected for an address outside the window, or missed for one inside it. A wait counter loaded with the wrong value, or reloaded in the middle of an access, moves the rising edge of `boot_dack` by one or more cycles within that same access. A width or wait count taken from a write made during the access shows as a mismatch before `bus_as` drops. Every access is therefore compared cycle by cycle against its expected profile, from the first edge after the strobe until the edge after release.

// File: rtl/bootcs_pkg.sv
package bootcs_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_SEL  = 2'd1,
    ACC_SKIP = 2'd2
  } acc_state_e;

  localparam logic [1:0] SEL_BASE = 2'd0;
  localparam logic [1:0] SEL_MASK = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  localparam int CTRL_VALID  = 0;
  localparam int CTRL_P16    = 1;
  localparam int CTRL_WS_LSB = 2;
endpackage

// File: rtl/bootcs_regs.sv
module bootcs_regs
  import bootcs_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int WS_W   = 4,
  parameter int RST_WS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] mask_o,
  output logic              valid_o,
  output logic              global_o,
  output logic              p16_o,
  output logic [WS_W-1:0]   ws_o
);
  localparam int WS_MSB = CTRL_WS_LSB + WS_W - 1;

  logic [ADDR_W-1:0] base_q, mask_q;
  logic              valid_q, global_q, p16_q;
  logic [WS_W-1:0]   ws_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      mask_q   <= '0;
      valid_q  <= 1'b0;
      global_q <= 1'b1;
      p16_q    <= 1'b1;
      ws_q     <= WS_W'(RST_WS);
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_BASE: base_q <= cfg_wdata;
        SEL_MASK: mask_q <= cfg_wdata;
        SEL_CTRL: begin
          valid_q <= cfg_wdata[CTRL_VALID];
          p16_q   <= cfg_wdata[CTRL_P16];
          ws_q    <= cfg_wdata[WS_MSB:CTRL_WS_LSB];
          if (cfg_wdata[CTRL_VALID]) global_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign base_o   = base_q;
  assign mask_o   = mask_q;
  assign valid_o  = valid_q;
  assign global_o = global_q;
  assign p16_o    = p16_q;
  assign ws_o     = ws_q;

  // Global decode, once left, stays off until reset.
  assert_global_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    !global_q |=> !global_q);

  // A set valid bit always means windowed decode.
  assert_valid_ends_global_R5: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> !global_q);
endmodule

// File: rtl/bootcs_decode.sv
module bootcs_decode #(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] mask,
  input  logic              valid,
  input  logic              global_en,
  output logic              hit
);
  logic [ADDR_W-1:0] diff;

  always_comb begin
    diff = (addr ^ base) & ~mask;
    hit  = global_en | (valid & (diff == '0));
  end
endmodule

// File: rtl/bootcs_timer.sv
module bootcs_timer
  import bootcs_pkg::*;
#(
  parameter int WS_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_as,
  input  logic            hit,
  input  logic [WS_W-1:0] ws_cfg,
  input  logic            p16_cfg,
  output logic            cs_o,
  output logic            dack_o,
  output logic            p16_o
);
  acc_state_e      st_q;
  logic [WS_W-1:0] cnt_q;
  logic            cs_q, dack_q, p16_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ACC_IDLE;
      cnt_q  <= '0;
      cs_q   <= 1'b0;
      dack_q <= 1'b0;
      p16_q  <= 1'b1;
    end else if (!bus_as) begin
      st_q   <= ACC_IDLE;
      cs_q   <= 1'b0;
      dack_q <= 1'b0;
    end else begin
      case (st_q)
        ACC_IDLE: begin
          if (hit) begin
            st_q  <= ACC_SEL;
            cs_q  <= 1'b1;
            cnt_q <= ws_cfg;
            p16_q <= p16_cfg;
          end else begin
            st_q <= ACC_SKIP;
          end
        end
        ACC_SEL: begin
          if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
          else             dack_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign cs_o   = cs_q;
  assign dack_o = dack_q;
  assign p16_o  = p16_q;

  assert_release_R9: assert property (@(posedge clk) disable iff (rst)
    !bus_as |=> (!cs_q && !dack_q));

  assert_ack_inside_select_R7: assert property (@(posedge clk) disable iff (rst)
    dack_q |-> cs_q);

  assert_no_ack_at_start_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_q) |-> !dack_q);

  assert_width_held_R10: assert property (@(posedge clk) disable iff (rst)
    (cs_q && $past(cs_q)) |-> $stable(p16_q));
endmodule

// File: rtl/boot_cs_ctrl.sv
module boot_cs_ctrl #(
  parameter int ADDR_W = 24,
  parameter int WS_W   = 4,
  parameter int RST_WS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_as,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic              boot_cs,
  output logic              boot_dack,
  output logic              boot_port16
);
  logic [ADDR_W-1:0] base_w, mask_w;
  logic              valid_w, global_w, p16_w, hit_w;
  logic [WS_W-1:0]   ws_w;

  bootcs_regs #(.ADDR_W(ADDR_W), .WS_W(WS_W), .RST_WS(RST_WS)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .base_o(base_w), .mask_o(mask_w),
    .valid_o(valid_w), .global_o(global_w), .p16_o(p16_w), .ws_o(ws_w)
  );

  bootcs_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr(bus_addr), .base(base_w), .mask(mask_w), .valid(valid_w),
    .global_en(global_w), .hit(hit_w)
  );

  bootcs_timer #(.WS_W(WS_W)) u_timer (
    .clk(clk), .rst(rst), .bus_as(bus_as), .hit(hit_w), .ws_cfg(ws_w),
    .p16_cfg(p16_w), .cs_o(boot_cs), .dack_o(boot_dack), .p16_o(boot_port16)
  );
endmodule

// File: tb/boot_cs_ctrl_tb.sv
module boot_cs_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;

  typedef struct {
    bit    hit;
    int    ws;
    bit    p16;
    string tag;
  } exp_t;

  logic          clk = 0, rst = 1, bus_as = 0, cfg_we = 0;
  logic [AW-1:0] bus_addr = '0, cfg_wdata = '0;
  logic [1:0]    cfg_sel = '0;
  logic          boot_cs, boot_dack, boot_port16;

  int checks = 0, fails = 0;
  exp_t q[$];

  // Reference model state
  bit m_global, m_valid, m_p16;
  int m_ws;
  logic [AW-1:0] m_base, m_mask;

  boot_cs_ctrl #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_as(bus_as),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .boot_cs(boot_cs), .boot_dack(boot_dack), .boot_port16(boot_port16)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_global = 1; m_valid = 0; m_p16 = 1; m_ws = 3; m_base = '0; m_mask = '0;
  endtask

  function automatic bit model_hit(input logic [AW-1:0] a);
    return m_global || (m_valid && (((a ^ m_base) & ~m_mask) == '0));
  endfunction

  task automatic model_write(input logic [1:0] s, input logic [AW-1:0] d);
    case (s)
      2'd0: m_base = d;
      2'd1: m_mask = d;
      2'd2: begin
        m_valid = d[0]; m_p16 = d[1]; m_ws = int'(d[5:2]);
        if (d[0]) m_global = 0;
      end
      default: ;
    endcase
  endtask

  task automatic cfg_write(input logic [1:0] s, input logic [AW-1:0] d);
    @(posedge clk); #1;
    cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 0;
    model_write(s, d);
  endtask

  function automatic logic [AW-1:0] ctrl_word(input bit v, input bit p16, input int ws);
    return AW'({ws[3:0], p16, v});
  endfunction

  // Driver: one bus access, optional configuration write in its middle.
  task automatic access(input logic [AW-1:0] a, input string tag,
                        input bit mid, input logic [1:0] ms, input logic [AW-1:0] md);
    exp_t e;
    @(posedge clk); #1;
    bus_addr = a; bus_as = 1;
    e.hit = model_hit(a); e.ws = m_ws; e.p16 = m_p16; e.tag = tag;
    q.push_back(e);
    if (mid) begin
      @(posedge clk); #1;
      cfg_we = 1; cfg_sel = ms; cfg_wdata = md;
      @(posedge clk); #1;
      cfg_we = 0;
      model_write(ms, md);
    end
    if (e.hit) begin
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (boot_dack) break;
      end
    end else begin
      repeat (6) @(negedge clk);
    end
    @(posedge clk); #1;
    bus_as = 0;
    repeat (3) @(posedge clk);
  endtask

  // Monitor: pops the expected profile and compares every cycle.
  bit in_acc = 0, drop_pend = 0;
  int k = 0;
  exp_t cur;
  always @(negedge clk) begin
    if (rst) begin
      in_acc = 0; drop_pend = 0;
    end else begin
      if (drop_pend) begin
        check(!boot_cs && !boot_dack, "R9 release", int'({boot_cs, boot_dack}), 0);
        drop_pend = 0;
      end
      if (bus_as && !in_acc) begin
        if (q.size() == 0) check(0, "scoreboard underflow", 0, 1);
        else cur = q.pop_front();
        in_acc = 1; k = 0;
      end else if (bus_as && in_acc) begin
        k++;
        check(boot_cs == cur.hit, {cur.tag, " select"}, int'(boot_cs), int'(cur.hit));
        check(boot_dack == (cur.hit && k >= cur.ws + 2), {cur.tag, " R7 ack timing"},
              int'(boot_dack), int'(cur.hit && k >= cur.ws + 2));
        if (cur.hit)
          check(boot_port16 == cur.p16, {cur.tag, " R8 width"},
                int'(boot_port16), int'(cur.p16));
      end else if (!bus_as && in_acc) begin
        in_acc = 0; drop_pend = 1;
      end
    end
  end

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1; bus_as = 0; cfg_we = 0;
    repeat (3) @(posedge clk); #1;
    rst = 0;
    model_reset();
    @(negedge clk);
    check(!boot_cs && !boot_dack, "R2 reset outputs", int'({boot_cs, boot_dack}), 0);
    check(boot_port16 == 1'b1, "R2 reset width", int'(boot_port16), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();
    // R3: vector fetch, four halfword cycles with default R2 timing
    access(24'h000000, "R3 ssp hi", 0, 0, 0);
    access(24'h000002, "R3 ssp lo", 0, 0, 0);
    access(24'h000004, "R3 pc hi", 0, 0, 0);
    access(24'h000006, "R3 pc lo", 0, 0, 0);
    // R1: global decode at scattered addresses, base/mask loaded but not valid
    cfg_write(2'd0, 24'h400000);      // R11 base
    cfg_write(2'd1, 24'h0FFFFF);      // R11 mask
    access(24'hC01234, "R1 global high", 0, 0, 0);
    access(24'h7FFFFE, "R1 global mid", 0, 0, 0);
    // R5: validate window 0x400000..0x4FFFFF, 2 waits, 16-bit
    cfg_write(2'd2, ctrl_word(1, 1, 2));
    access(24'h400000, "R5 in low", 0, 0, 0);
    access(24'h4ABCDE, "R5 in high", 0, 0, 0);
    access(24'h000000, "R5 out zero", 0, 0, 0);
    access(24'h500000, "R5 out above", 0, 0, 0);
    // R7: wait count extremes, R8 8-bit width
    cfg_write(2'd2, ctrl_word(1, 0, 0));
    access(24'h410000, "R7 ws0 R8 p8", 0, 0, 0);
    cfg_write(2'd2, ctrl_word(1, 1, 15));
    access(24'h420000, "R7 ws15", 0, 0, 0);
    // R10: write during access changes only the next one
    access(24'h430000, "R10 during", 1, 2'd2, ctrl_word(1, 0, 1));
    access(24'h430002, "R10 after", 0, 0, 0);
    // R4: mask with holes
    cfg_write(2'd0, 24'h123456);
    cfg_write(2'd1, 24'h00FF00);
    access(24'h12AB56, "R4 hole hit", 0, 0, 0);
    access(24'h12AB57, "R4 low bit miss", 0, 0, 0);
    access(24'h13AB56, "R4 high bit miss", 0, 0, 0);
    // R6: clearing valid does not bring back global decode
    cfg_write(2'd2, ctrl_word(0, 1, 3));
    access(24'h12AB56, "R6 cleared window", 0, 0, 0);
    access(24'h000000, "R6 no global", 0, 0, 0);
    // R1 again: system reset restores global decode
    do_reset();
    access(24'h999998, "R1 after reset", 0, 0, 0);
    check(q.size() == 0, "scoreboard drained", q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule